// File: doc/BRIEF.md
# Column-Scanned Dot Matrix Refresh Driver

This block refreshes an emissive dot matrix of 8 rows by 64 columns. It selects one column at a time through a 6-bit binary column address and steps through all columns in order at a fixed rate. While a column is selected, the 8 row lines carry that column's pixel data. Any mix of the rows may be high at the same time.

Each pixel holds a gray code. Brightness is set by how long the row line stays high inside the column slot. A slot lasts `SUB_CYC * 2^GRAY_BITS` clocks and is split into `2^GRAY_BITS` subticks. Writes go through a plain address/data port into a staging buffer. The whole staging buffer is copied into the display buffer when a frame ends, so the image never tears. A scroll input, taken once per frame, rotates which buffer column lands on each physical column, so text can be moved across the screen.

Picking the slot length sets the refresh rate. For the image to look steady, the full frame must repeat above roughly 40 Hz. A slot near 365 µs gives a frame of about 23.4 ms.

Top module: `dotmatrix_scan`

## Requirements
- R1: `col_addr` holds each value for exactly SLOT_LEN = SUB_CYC*2^GRAY_BITS clocks (32 by default), then increments by one, and wraps from 63 to 0.
- R2: While `rst` is high, `col_addr` is 0, `row_out` is all zero and `frame_start` is low.
- R3: In the first clock of every column slot, all bits of `row_out` are low.
- R4: In slot clock k (counted from 0), row r is high exactly when k >= 1 and floor(k/SUB_CYC) is less than the pixel's code. Code 0 is never lit, and a nonzero code c is lit for c*SUB_CYC-1 clocks per slot.
- R5: Bit r of `row_out` drives row r (bit 0 is row 0), and any subset of the rows may be high in the same clock.
- R6: A pixel write is not shown in the frame during which it is made. It is shown from the next frame on, because the staging buffer is copied on the clock edge that ends column 63.
- R7: `scroll_off` is sampled only on the edge that ends column 63. During the frame that follows, physical column c shows buffer column (c + offset) mod 64. A change made mid-frame has no effect until the next frame.
- R8: `frame_start` is high for exactly one clock per frame: the first clock of column 0.
- R9: A write with `wr_en` high stores `wr_code` as the pixel at row `wr_row` and buffer column `wr_col`. The reset contents are all code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Pixel write strobe |
| wr_row | input | 3 | Row index of the write |
| wr_col | input | 6 | Buffer column of the write |
| wr_code | input | 4 | Gray code to store |
| scroll_off | input | 6 | Column rotation for the next frame |
| col_addr | output | 6 | Binary address of the selected column |
| row_out | output | 8 | Row drive lines for the selected column |
| frame_start | output | 1 | High in the first clock of column 0 |

## Verification
The outputs are decoded with no register from the counter and buffer state, so each output follows the clock edge that updates that state. Row levels, the column address and `frame_start` are therefore read at the falling edge that follows that rising edge. A write is due one full frame boundary later, and a scroll value is due in the frame after the boundary edge. The bench walks each frame one clock at a time from `frame_start`. It counts the lit clocks of each pixel per slot against code*SUB_CYC-1, and checks the blank first clock and the row mask at slot clock 1. Writes and scroll changes are driven well inside a frame, so that the frame being measured must still show the old data and offset.

// File: rtl/dm_scan_pkg.sv
package dm_scan_pkg;

   // Column-mapping variant picked at elaboration time
   typedef enum logic [0:0] {
      COLMAP_WRAP = 1'b0,   // column count is a power of two: plain wrap-around add
      COLMAP_FOLD = 1'b1    // other counts: add, then subtract once on overflow
   } colmap_e;

   function automatic colmap_e pick_colmap(input int cols, input int col_bits);
      return (cols == (1 << col_bits)) ? COLMAP_WRAP : COLMAP_FOLD;
   endfunction

endpackage

// File: rtl/dm_col_timer.sv
module dm_col_timer #(
   parameter int COLS      = 64,
   parameter int COL_BITS  = 6,
   parameter int GRAY_BITS = 4,
   parameter int SUB_CYC   = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   output logic [COL_BITS-1:0]  col_o,
   output logic [GRAY_BITS-1:0] sub_o,
   output logic                 slot_first_o,
   output logic                 frame_last_o
);
   localparam int DIV_W = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1;

   logic                 div_last;
   logic                 div_zero;
   logic [GRAY_BITS-1:0] sub_q;
   logic [COL_BITS-1:0]  col_q;
   logic                 slot_last;

   generate
      if (SUB_CYC == 1) begin : g_nodiv
         assign div_last = 1'b1;
         assign div_zero = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk) begin
            if (rst)
               div_q <= '0;
            else if (div_q == DIV_W'(SUB_CYC - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign div_last = (div_q == DIV_W'(SUB_CYC - 1));
         assign div_zero = (div_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         sub_q <= '0;
      else if (div_last)
         sub_q <= sub_q + 1'b1;
   end

   assign slot_last = div_last && (sub_q == {GRAY_BITS{1'b1}});

   always_ff @(posedge clk) begin
      if (rst)
         col_q <= '0;
      else if (slot_last) begin
         if (col_q == COL_BITS'(COLS - 1))
            col_q <= '0;
         else
            col_q <= col_q + 1'b1;
      end
   end

   assign col_o        = col_q;
   assign sub_o        = sub_q;
   assign slot_first_o = div_zero && (sub_q == '0);
   assign frame_last_o = slot_last && (col_q == COL_BITS'(COLS - 1));

endmodule

// File: rtl/dm_frame_store.sv
module dm_frame_store #(
   parameter int ROWS      = 8,
   parameter int COLS      = 64,
   parameter int COL_BITS  = 6,
   parameter int GRAY_BITS = 4,
   parameter int ROW_W     = 3
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_en,
   input  logic [ROW_W-1:0]                   wr_row,
   input  logic [COL_BITS-1:0]                wr_col,
   input  logic [GRAY_BITS-1:0]               wr_code,
   input  logic                               swap,
   input  logic [COL_BITS-1:0]                rd_col,
   output logic [ROWS-1:0][GRAY_BITS-1:0]     rd_codes
);
   logic [GRAY_BITS-1:0] stage_mem [ROWS][COLS];
   logic [GRAY_BITS-1:0] show_mem  [ROWS][COLS];
   logic                 wr_ok;

   assign wr_ok = wr_en && (int'(wr_row) < ROWS) && (int'(wr_col) < COLS);

   // Staging copy, written by the pixel port
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               stage_mem[r][c] <= '0;
      end else if (wr_ok) begin
         stage_mem[wr_row][wr_col] <= wr_code;
      end
   end

   // Displayed copy, loaded whole at the frame boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               show_mem[r][c] <= '0;
      end else if (swap) begin
         show_mem <= stage_mem;
      end
   end

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_rd
         assign rd_codes[r] = show_mem[r][rd_col];
      end
   endgenerate

endmodule

// File: rtl/dm_row_pwm.sv
module dm_row_pwm #(
   parameter int ROWS      = 8,
   parameter int GRAY_BITS = 4
) (
   input  logic                           blank,
   input  logic [GRAY_BITS-1:0]           sub,
   input  logic [ROWS-1:0][GRAY_BITS-1:0] codes,
   output logic [ROWS-1:0]                rows
);
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign rows[r] = !blank && (sub < codes[r]);
      end
   endgenerate
endmodule

// File: rtl/dotmatrix_scan.sv
module dotmatrix_scan #(
   parameter int ROWS      = 8,
   parameter int COLS      = 64,
   parameter int COL_BITS  = 6,
   parameter int GRAY_BITS = 4,
   parameter int SUB_CYC   = 2,
   parameter int ROW_W     = $clog2(ROWS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [ROW_W-1:0]     wr_row,
   input  logic [COL_BITS-1:0]  wr_col,
   input  logic [GRAY_BITS-1:0] wr_code,
   input  logic [COL_BITS-1:0]  scroll_off,
   output logic [COL_BITS-1:0]  col_addr,
   output logic [ROWS-1:0]      row_out,
   output logic                 frame_start
);
   import dm_scan_pkg::*;

   localparam int      SLOT_LEN = SUB_CYC << GRAY_BITS;
   localparam colmap_e COL_MAP  = pick_colmap(COLS, COL_BITS);

   // Elaboration-time parameter checks
   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("dotmatrix_scan: ROWS must be at least 2");
      end
      if (COLS < 2 || COLS > (1 << COL_BITS)) begin : g_bad_cols
         $error("dotmatrix_scan: COLS must lie in 2 .. 2**COL_BITS");
      end
      if (GRAY_BITS < 1 || SUB_CYC < 1) begin : g_bad_gray
         $error("dotmatrix_scan: GRAY_BITS and SUB_CYC must be positive");
      end
      if (ROW_W != $clog2(ROWS)) begin : g_bad_roww
         $error("dotmatrix_scan: ROW_W must equal clog2(ROWS)");
      end
   endgenerate

   logic [COL_BITS-1:0]           col_q;
   logic [GRAY_BITS-1:0]          sub_q;
   logic                          slot_first;
   logic                          frame_last;
   logic [COL_BITS-1:0]           off_q;
   logic [COL_BITS-1:0]           off_next;
   logic [COL_BITS-1:0]           buf_col;
   logic [ROWS-1:0][GRAY_BITS-1:0] codes;
   logic [ROWS-1:0]               rows_raw;

   dm_col_timer #(
      .COLS(COLS), .COL_BITS(COL_BITS), .GRAY_BITS(GRAY_BITS), .SUB_CYC(SUB_CYC)
   ) u_timer (
      .clk          (clk),
      .rst          (rst),
      .col_o        (col_q),
      .sub_o        (sub_q),
      .slot_first_o (slot_first),
      .frame_last_o (frame_last)
   );

   // Physical-to-buffer column rotation
   generate
      if (COL_MAP == COLMAP_WRAP) begin : g_map_wrap
         assign buf_col  = col_q + off_q;
         assign off_next = scroll_off;
      end else begin : g_map_fold
         logic [COL_BITS:0] sum;
         assign sum      = {1'b0, col_q} + {1'b0, off_q};
         assign buf_col  = (int'(sum) >= COLS) ? COL_BITS'(int'(sum) - COLS)
                                               : sum[COL_BITS-1:0];
         assign off_next = (int'(scroll_off) < COLS) ? scroll_off : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         off_q <= '0;
      else if (frame_last)
         off_q <= off_next;
   end

   dm_frame_store #(
      .ROWS(ROWS), .COLS(COLS), .COL_BITS(COL_BITS),
      .GRAY_BITS(GRAY_BITS), .ROW_W(ROW_W)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_row   (wr_row),
      .wr_col   (wr_col),
      .wr_code  (wr_code),
      .swap     (frame_last),
      .rd_col   (buf_col),
      .rd_codes (codes)
   );

   dm_row_pwm #(
      .ROWS(ROWS), .GRAY_BITS(GRAY_BITS)
   ) u_pwm (
      .blank (slot_first),
      .sub   (sub_q),
      .codes (codes),
      .rows  (rows_raw)
   );

   assign col_addr    = col_q;
   assign row_out     = rows_raw;
   assign frame_start = !rst && slot_first && (col_q == '0);

endmodule

// File: rtl/dotmatrix_scan_chk.sv
module dotmatrix_scan_chk #(
   parameter int ROWS     = 8,
   parameter int COL_BITS = 6,
   parameter int SLOT     = 32
) (
   input logic                clk,
   input logic                rst,
   input logic [COL_BITS-1:0] col_addr,
   input logic [ROWS-1:0]     row_out,
   input logic                frame_start
);
   localparam int HW = $clog2(SLOT) + 1;

   logic [HW-1:0]       hold_q;
   logic [COL_BITS-1:0] col_prev;
   logic                col_moved;

   always_ff @(posedge clk) begin
      if (rst) col_prev <= '0;
      else     col_prev <= col_addr;
   end
   assign col_moved = (col_addr != col_prev);

   // Clocks since the last column change
   always_ff @(posedge clk) begin
      if (rst)            hold_q <= '0;
      else if (col_moved) hold_q <= HW'(1);
      else                hold_q <= hold_q + 1'b1;
   end

   // R1: the column moves by exactly one step
   p_col_step_r1: assert property (@(posedge clk) disable iff (rst)
      col_moved |-> (col_addr == col_prev + 1'b1));

   // R1: the column was held for a full slot before it moved
   p_slot_len_r1: assert property (@(posedge clk) disable iff (rst)
      col_moved |-> (int'(hold_q) == SLOT));

   // R3: no row is lit in the clock of a column change
   p_blank_r3: assert property (@(posedge clk) disable iff (rst)
      col_moved |-> (row_out == '0));

   // R8: frame_start falls on column 0 with the rows blanked
   p_fs_col0_r8: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (col_addr == '0 && row_out == '0));

   // R8: frame_start lasts one clock
   p_fs_single_r8: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);

endmodule

bind dotmatrix_scan dotmatrix_scan_chk #(
   .ROWS(ROWS), .COL_BITS(COL_BITS), .SLOT(SLOT_LEN)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .col_addr    (col_addr),
   .row_out     (row_out),
   .frame_start (frame_start)
);

// File: tb/dotmatrix_scan_bench.sv
module dotmatrix_scan_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ROWS  = 8;
   localparam int COLS  = 64;
   localparam int CB    = 6;
   localparam int GB    = 4;
   localparam int SUB   = 2;
   localparam int SLOT  = SUB << GB;
   localparam int WD_CYCLES = 60000;

   // Stimulus vectors: {row, column, code, expected lit clocks per slot}
   typedef struct packed {
      logic [2:0] row;
      logic [5:0] col;
      logic [3:0] code;
      logic [7:0] lit;
   } vec_t;
   localparam vec_t TAB [12] = '{
      '{3'd0, 6'd10, 4'd15, 8'd29},
      '{3'd1, 6'd10, 4'd1,  8'd1 },
      '{3'd2, 6'd10, 4'd7,  8'd13},
      '{3'd3, 6'd10, 4'd3,  8'd5 },
      '{3'd4, 6'd10, 4'd9,  8'd17},
      '{3'd5, 6'd10, 4'd12, 8'd23},
      '{3'd6, 6'd10, 4'd2,  8'd3 },
      '{3'd7, 6'd10, 4'd5,  8'd9 },
      '{3'd0, 6'd0,  4'd4,  8'd7 },
      '{3'd7, 6'd63, 4'd8,  8'd15},
      '{3'd5, 6'd32, 4'd15, 8'd29},
      '{3'd3, 6'd33, 4'd0,  8'd0 }
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_row = '0;
   logic [CB-1:0] wr_col = '0;
   logic [GB-1:0] wr_code = '0;
   logic [CB-1:0] scroll_off = '0;
   logic [CB-1:0] col_addr;
   logic [ROWS-1:0] row_out;
   logic          frame_start;

   int checks = 0;
   int errors = 0;
   int exp_cur [ROWS][COLS];
   int exp_nxt [ROWS][COLS];

   always #(CLK_PERIOD/2) clk = ~clk;

   dotmatrix_scan u_dotmatrix_scan (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
      .wr_code(wr_code), .scroll_off(scroll_off), .col_addr(col_addr),
      .row_out(row_out), .frame_start(frame_start)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int lit_of(input int code);
      return (code == 0) ? 0 : code * SUB - 1;
   endfunction

   task automatic wr_px(input int r, input int c, input int code);
      @(negedge clk);
      wr_en = 1'b1; wr_row = 3'(r); wr_col = CB'(c); wr_code = GB'(code);
      @(negedge clk);
      wr_en = 1'b0;
      exp_nxt[r][c] = code;
   endtask

   // Walk one full frame from its first clock, sampling between edges
   task automatic scan_frame(input int off, input string tag);
      int fs_bad = 0;
      chk(frame_start === 1'b1, {"R8 frame_start at frame begin ", tag}, int'(frame_start), 1);
      for (int c = 0; c < COLS; c++) begin
         int cnt [ROWS];
         int col_bad = 0;
         int blank_bad = 0;
         int mask_k1 = 0;
         int bc = (c + off) % COLS;
         int exp_mask = 0;
         for (int r = 0; r < ROWS; r++) begin
            cnt[r] = 0;
            if (exp_cur[r][bc] != 0) exp_mask |= (1 << r);
         end
         for (int k = 0; k < SLOT; k++) begin
            if (int'(col_addr) != c) col_bad = int'(col_addr) + 1000;
            if (k == 0 && row_out != '0) blank_bad = 1;
            if (k == 1) mask_k1 = int'(row_out);
            if (frame_start && !(c == 0 && k == 0)) fs_bad = 1;
            for (int r = 0; r < ROWS; r++) cnt[r] += int'(row_out[r]);
            @(negedge clk);
         end
         chk(col_bad == 0, {"R1 column address ", tag}, col_bad, c);
         chk(blank_bad == 0, {"R3 blank first clock ", tag}, blank_bad, 0);
         chk(mask_k1 == exp_mask, {"R5 row mask at slot clock 1 ", tag}, mask_k1, exp_mask);
         for (int r = 0; r < ROWS; r++)
            chk(cnt[r] == lit_of(exp_cur[r][bc]),
                {"R4 R9 lit clocks per slot ", tag}, cnt[r], lit_of(exp_cur[r][bc]));
      end
      chk(fs_bad == 0, {"R8 single frame_start ", tag}, fs_bad, 0);
   endtask

   task automatic commit_frame();
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            exp_cur[r][c] = exp_nxt[r][c];
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            exp_cur[r][c] = 0;
            exp_nxt[r][c] = 0;
         end

      // R2: reset state
      repeat (4) @(negedge clk);
      chk(col_addr == '0, "R2 reset column", int'(col_addr), 0);
      chk(row_out == '0, "R2 reset rows", int'(row_out), 0);
      chk(frame_start == 1'b0, "R2 reset frame_start", int'(frame_start), 0);
      rst = 1'b0;
      #1;

      // Frame 0: display still blank while the vector table is written
      fork
         scan_frame(0, "F0 R6");
         begin
            for (int i = 0; i < 12; i++)
               wr_px(int'(TAB[i].row), int'(TAB[i].col), int'(TAB[i].code));
         end
      join
      commit_frame();
      // Table expectations against the computed lit count
      for (int i = 0; i < 12; i++)
         chk(lit_of(exp_cur[TAB[i].row][TAB[i].col]) == int'(TAB[i].lit),
             "R4 vector table lit count", lit_of(exp_cur[TAB[i].row][TAB[i].col]),
             int'(TAB[i].lit));

      // Frame 1: table shown; new pixel and scroll change held back
      fork
         scan_frame(0, "F1 R6 R7");
         begin
            wr_px(2, 40, 9);
            wr_px(0, 10, 0);
            repeat (900) @(negedge clk);
            scroll_off = CB'(5);
         end
      join
      commit_frame();

      // Frame 2: offset 5 in force; a mid-frame change must wait
      fork
         scan_frame(5, "F2 R7");
         begin
            repeat (700) @(negedge clk);
            scroll_off = CB'(20);
         end
      join

      // Frame 3: offset 20, wrapping past column 63
      scan_frame(20, "F3 R7");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule